// File: doc/BRIEF.md
# Supervisory Reset Timing Controller

This block generates the system reset for a supply supervisor. It has three inputs. The first is a "supply above threshold" flag from an external comparator. The second is an active-low pushbutton input. The third is the sensed level of a shared open-drain reset pin.

A single timeout counter turns these three sources into one reset. The counter is reloaded on every cycle that a source is active. Reset is released only after the counter runs down to zero. The block never drives the pin high. When reset is active it enables the pull-down. When reset ends it lets the external pull-up set the level.

Short low glitches are filtered out, both on the supply flag and on the pushbutton. An external device that pulls the shared pin low starts a full timeout, even if it pulls it low for only one cycle. The block's own drive on the pin is masked, so releasing the pin never retriggers the timer. All lengths are parameters in clock cycles: the timeout, the supply filter and the pushbutton filter.

Top module: `sup_rst_timer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `pin_pd_en_o` and `rst_flag_o` are both 1. These two outputs are always equal. A value of 1 means reset is active and the pin pull-down is enabled.
- R2: When `supply_ok_i` is low for at least `SUP_FILT` consecutive cycles, reset is asserted. Reset then stays asserted for as long as the flag stays low.
- R3: A low pulse on `supply_ok_i` that lasts `SUP_FILT-1` cycles or less never asserts reset.
- R4: Each input passes through a two-flop synchronizer. For a low pulse of L ≥ `SUP_FILT` cycles on `supply_ok_i`, starting from idle, reset is high for exactly L + `TIMEOUT_CYC` - `SUP_FILT` cycles. After a long low period, reset stays high for `TIMEOUT_CYC`+2 cycles once the flag rises.
- R5: When `man_rst_n_i` is low for at least `MAN_FILT` consecutive cycles, reset is asserted. Reset then stays asserted while the input stays low.
- R6: A low pulse on `man_rst_n_i` that lasts `MAN_FILT-1` cycles or less never asserts reset.
- R7: For a pushbutton low pulse of L ≥ `MAN_FILT` cycles, starting from idle, reset is high for exactly L + `TIMEOUT_CYC` - `MAN_FILT` cycles.
- R8: A high-to-low transition on `pin_lvl_i` while the block is not driving the pin starts reset. Reset then lasts exactly `TIMEOUT_CYC` cycles, even when the external low pulse lasts only 1 to 3 cycles.
- R9: The block's own drive and release of the pin never start a new timeout. After a pin-triggered reset ends, reset stays low while all inputs stay idle.
- R10: A trigger that arrives during an active timeout reloads the counter to its full value. A pushbutton pulse of `MAN_FILT` cycles that starts while reset is high keeps reset high for `MAN_FILT` + `TIMEOUT_CYC` + 2 cycles from the start of the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block's logic |
| supply_ok_i | input | 1 | Supply-above-threshold flag from the comparator (asynchronous) |
| man_rst_n_i | input | 1 | Active-low pushbutton input (asynchronous) |
| pin_lvl_i | input | 1 | Sensed level of the shared open-drain reset pin |
| pin_pd_en_o | output | 1 | 1 enables the pin pull-down (reset active); 0 leaves the pin released |
| rst_flag_o | output | 1 | Internal active-high reset flag |

## Verification
A stuck or mis-loaded counter shows up as a wrong reset width, so every scenario measures the exact number of high cycles at the outputs. A filter count that is off by one shows up in the boundary pulses. A pulse one cycle below the threshold must leave reset low, and a pulse at the threshold must produce a width predicted to the cycle. A broken pin mask shows up within a few cycles of release, as an endless chain of self-retriggered resets. A missing reload shows up as a release that comes too early, well before the expected width.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

  // Next value of the low-level glitch filter counter.
  // It counts cycles of a low input, saturates at the limit, and clears on high.
  function automatic int unsigned filt_next(int unsigned cur, logic is_low,
                                            int unsigned limit);
    if (!is_low)         return 0;
    else if (cur >= limit) return limit;
    else                 return cur + 1;
  endfunction

  // Next value of the reset timeout counter.
  // It reloads to full on a trigger; otherwise it counts down to zero.
  function automatic int unsigned timer_next(int unsigned cur, logic load,
                                             int unsigned full);
    if (load)          return full;
    else if (cur != 0) return cur - 1;
    else               return 0;
  endfunction

endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
  parameter int unsigned      W       = 1,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d[i];
        s2_q <= s1_q;
      end
    end
    assign q[i] = s2_q;
  end
endmodule

// File: rtl/rstgen_lowfilt.sv
module rstgen_lowfilt
  import rstgen_pkg::*;
#(
  parameter int unsigned LIMIT = 4,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,       // synchronized level; low is the condition being filtered
  output logic qual_low   // low level has lasted LIMIT cycles
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign cnt_d    = CW'(filt_next(32'(cnt_q), !lvl, LIMIT));
  assign qual_low = (32'(cnt_q) == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // A qualified low needs a low level in the cycle before it.
  AST_QUAL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    qual_low |-> !$past(lvl));  // R3
  // A high level always clears the qualification on the next cycle.
  AST_HIGH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    lvl |=> !qual_low);  // R6
endmodule

// File: rtl/rstgen_timer.sv
module rstgen_timer
  import rstgen_pkg::*;
#(
  parameter int unsigned TIMEOUT = 16,
  localparam int unsigned CW     = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign cnt_d  = CW'(timer_next(32'(cnt_q), trig, TIMEOUT));
  assign active = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CW'(TIMEOUT);
    else        cnt_q <= cnt_d;
  end

  // A trigger always yields the full count on the next cycle.
  AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (32'(cnt_q) == TIMEOUT));  // R10
  // Release never follows a cycle that had a trigger.
  AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> !$past(trig));  // R8
  // Once reset starts it lasts at least two cycles.
  AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |=> active);  // R8
endmodule

// File: rtl/sup_rst_timer.sv
module sup_rst_timer #(
  parameter int unsigned TIMEOUT_CYC = 25_000_000,
  parameter int unsigned SUP_FILT    = 4,
  parameter int unsigned MAN_FILT    = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic man_rst_n_i,
  input  logic pin_lvl_i,
  output logic pin_pd_en_o,
  output logic rst_flag_o
);
  // Bit order of the synchronized vector.
  localparam int unsigned IDX_SUP = 0;
  localparam int unsigned IDX_MAN = 1;
  localparam int unsigned IDX_PIN = 2;
  localparam int unsigned NSYNC   = 3;

  logic [NSYNC-1:0] raw_vec, syn_vec;
  logic sup_s, man_s, pin_s;
  logic sup_bad, man_low, pin_fall, trig, active;
  logic pin_prev_q, drive_d1_q;

  assign raw_vec[IDX_SUP] = supply_ok_i;
  assign raw_vec[IDX_MAN] = man_rst_n_i;
  assign raw_vec[IDX_PIN] = pin_lvl_i;

  rstgen_sync #(.W(NSYNC), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_vec), .q(syn_vec)
  );

  assign sup_s = syn_vec[IDX_SUP];
  assign man_s = syn_vec[IDX_MAN];
  assign pin_s = syn_vec[IDX_PIN];

  rstgen_lowfilt #(.LIMIT(SUP_FILT)) u_sup_filt (
    .clk(clk), .rst_n(rst_n), .lvl(sup_s), .qual_low(sup_bad)
  );

  rstgen_lowfilt #(.LIMIT(MAN_FILT)) u_man_filt (
    .clk(clk), .rst_n(rst_n), .lvl(man_s), .qual_low(man_low)
  );

  // Falling-edge detection on the shared pin. It is masked while the block
  // drives the pin and for one cycle after it lets go.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev_q <= 1'b0;
      drive_d1_q <= 1'b1;
    end else begin
      pin_prev_q <= pin_s;
      drive_d1_q <= active;
    end
  end

  assign pin_fall = pin_prev_q & ~pin_s & ~active & ~drive_d1_q;
  assign trig     = sup_bad | man_low | pin_fall;

  rstgen_timer #(.TIMEOUT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .trig(trig), .active(active)
  );

  assign pin_pd_en_o = active;
  assign rst_flag_o  = active;

  AST_SUPPLY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    sup_bad |=> rst_flag_o);  // R2
  AST_BUTTON_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    man_low |=> rst_flag_o);  // R5
  AST_PIN_EDGE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    pin_fall |=> rst_flag_o);  // R8
  AST_NO_SELF_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    pin_fall |-> !$past(pin_pd_en_o));  // R9
  AST_OUTPUTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pd_en_o == rst_flag_o);  // R1
endmodule

// File: tb/sup_rst_timer_tb.sv
module sup_rst_timer_tb;
  localparam int T  = 20;
  localparam int SF = 3;
  localparam int MF = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic man_n = 1'b1;
  logic ext_low = 1'b0;
  logic pin_lvl;
  logic pin_pd_en_o, rst_flag_o;
  int   n_tests = 0;
  int   n_fail  = 0;
  logic done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  // Pad model: a wired-low line with a pull-up.
  assign pin_lvl = !(pin_pd_en_o || ext_low);

  sup_rst_timer #(.TIMEOUT_CYC(T), .SUP_FILT(SF), .MAN_FILT(MF)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .man_rst_n_i(man_n),
    .pin_lvl_i(pin_lvl), .pin_pd_en_o(pin_pd_en_o), .rst_flag_o(rst_flag_o)
  );

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Source select: 0 supply, 1 pushbutton, 2 external pin.
  // Drives a low pulse of len cycles and counts the sampled high cycles of
  // reset over a window of win cycles.
  task automatic pulse_count(int src, int len, int win, output int highs);
    highs = 0;
    @(negedge clk);
    case (src)
      0: supply_ok = 1'b0;
      1: man_n     = 1'b0;
      default: ext_low = 1'b1;
    endcase
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (rst_flag_o) highs++;
      if (rst_flag_o != pin_pd_en_o) check("R1 outputs agree", 0, 1);
      if (i == len - 1) begin
        supply_ok = 1'b1;
        man_n     = 1'b1;
        ext_low   = 1'b0;
      end
    end
  endtask

  task automatic idle_count(int win, output int highs);
    highs = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (rst_flag_o) highs++;
    end
  endtask

  task automatic t_power_up();
    int h;
    @(negedge clk);
    check("R1 pull-down in reset", int'(pin_pd_en_o), 1);
    check("R1 flag in reset", int'(rst_flag_o), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset release", int'(rst_flag_o), 1);
    idle_count(3 * T, h);
    check("R2 held while supply low", h, 3 * T);
    supply_ok = 1'b1;
    idle_count(T + 12, h);
    check("R4 release after supply rise", h, T + 2);
  endtask

  task automatic t_supply();
    int h;
    pulse_count(0, SF - 1, SF + T + 12, h);
    check("R3 supply glitch ignored", h, 0);
    pulse_count(0, SF, SF + T + 12, h);
    check("R4 supply pulse at threshold", h, T);
    pulse_count(0, 2 * T, 3 * T + 12, h);
    check("R2 R4 long supply dip", h, 2 * T + T - SF);
  endtask

  task automatic t_button();
    int h;
    pulse_count(1, MF - 1, MF + T + 12, h);
    check("R6 button glitch ignored", h, 0);
    pulse_count(1, MF, MF + T + 12, h);
    check("R7 button pulse at threshold", h, T);
    pulse_count(1, 3 * T, 4 * T + 12, h);
    check("R5 R7 button held", h, 3 * T + T - MF);
  endtask

  task automatic t_pin();
    int h;
    pulse_count(2, 1, T + 12, h);
    check("R8 one-cycle pin pulse", h, T);
    idle_count(3 * T, h);
    check("R9 no self retrigger", h, 0);
    pulse_count(2, 3, T + 12, h);
    check("R8 three-cycle pin pulse", h, T);
    idle_count(2 * T, h);
    check("R9 idle after pin reset", h, 0);
  endtask

  task automatic t_reload();
    int h;
    pulse_count(2, 1, 8, h);
    check("R10 pin reset under way", int'(rst_flag_o), 1);
    pulse_count(1, MF, MF + T + 12, h);
    check("R10 reload during timeout", h, MF + T + 2);
  endtask

  initial begin
    t_power_up();
    t_supply();
    t_button();
    t_pin();
    t_reload();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule